// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt sources. It shapes each one by its polarity and its trigger mode, latches them as pending status and masks them with a per-source enable. Each enabled pending source drives one of two processor-facing lines, critical or normal. Software uses a small word-addressed register bus, with single-cycle writes and a combinational read path. The bus can inspect the conditioned status, clear it, force it, and configure the sources.

The vector register gives a handler address directly. That address is a software-chosen base plus a 512-byte slot for the winning source. One configuration bit chooses which end of the source range wins. The slot index is mirrored to match the chosen end, so the top-priority source always owns slot 0. The expected handler flow is as follows: take the line, read the vector, jump, and clear the status bit with a write-one-to-clear.

The block has no state machine. All state sits in flat per-source registers: synchronizers, the previous active level, status, enable, critical select, polarity and trigger. A single configuration word completes the state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source N occupies register bit 31−N. Word offsets are 0x00 status (read, write-one-to-clear), 0x04 status set, 0x08 enable, 0x0C critical select, 0x10 polarity, 0x14 trigger, 0x18 masked status, 0x1C vector and 0x20 vector configuration. After reset, every register reads zero except polarity, which reads 0xFFFFFFFF.
- R2: A level-sensitive source (trigger bit 0) is pulled into the status through a two-flop synchronizer. Its status bit is set while the source stays active.
- R3: A polarity bit of 1 makes its source active when high. A polarity bit of 0 makes it active when low.
- R4: An edge-sensitive source (trigger bit 1) sets its status once per inactive-to-active transition. After a clear, the bit stays clear while the input remains active.
- R5: Writing 1 to a status bit clears it. If a level-sensitive source is still active, its bit is pending again right after the clear.
- R6: Writing 1 to a bit of the status-set word makes that source pending. The status-set word reads as zero.
- R7: Masked status reads as status AND enable.
- R8: `irq_crit` is high when any masked pending source has its critical-select bit at 1. `irq_norm` is high when any masked pending source has that bit at 0.
- R9: With configuration bit 0 = 1, the lowest-numbered masked pending source N wins. The vector then reads (config AND NOT 3) + N×512.
- R10: With configuration bit 0 = 0, the highest-numbered masked pending source N wins. The vector then reads (config AND NOT 3) + (31−N)×512.
- R11: The vector reads zero when no masked source is pending. The configuration word reads back exactly as written.
- R12: Writes to the masked-status and vector offsets have no effect. Reads of unmapped or unaligned addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 32 | Raw interrupt inputs, bit N is source N |
| irq_crit | output | 1 | Critical interrupt request |
| irq_norm | output | 1 | Non-critical interrupt request |

## Verification
The assertions check, on every cycle, the following per-bit properties:
- a cleared status bit is really clear afterwards, unless something set it in the same cycle;
- a forced bit lands;
- an edge-mode set pulse never lasts two cycles;
- the vector winner is itself a masked pending source;
- a raised request line always has an enabled pending source behind it.

Only the bench's scenarios can show the end-to-end behaviour:
- the synchronizer latency;
- the polarity and trigger combinations;
- a level source re-asserting after a clear;
- the exact vector values for both priority directions against the bench's own model.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

    localparam int REG_W = 32;

    // Word index of each register (byte offset / 4)
    localparam logic [3:0] WIX_STATUS = 4'h0;
    localparam logic [3:0] WIX_FORCE  = 4'h1;
    localparam logic [3:0] WIX_ENABLE = 4'h2;
    localparam logic [3:0] WIX_CRIT   = 4'h3;
    localparam logic [3:0] WIX_POL    = 4'h4;
    localparam logic [3:0] WIX_TRIG   = 4'h5;
    localparam logic [3:0] WIX_MASKED = 4'h6;
    localparam logic [3:0] WIX_VECTOR = 4'h7;
    localparam logic [3:0] WIX_CONFIG = 4'h8;

    // Source N lives at register bit REG_W-1-N: a plain bit reversal.
    function automatic logic [REG_W-1:0] rev_bits(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        for (int i = 0; i < REG_W; i++) begin
            r[REG_W-1-i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_condition.sv
module irq_condition #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_raw,
    input  logic [NSRC-1:0] pol_high,
    input  logic [NSRC-1:0] edge_mode,
    output logic [NSRC-1:0] hw_set
);

    logic [NSRC-1:0] sync1_q;
    logic [NSRC-1:0] sync2_q;
    logic [NSRC-1:0] active;
    logic [NSRC-1:0] active_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q    <= '0;
            sync2_q    <= '0;
            active_d_q <= '0;
        end else begin
            sync1_q    <= irq_raw;
            sync2_q    <= sync1_q;
            active_d_q <= active;
        end
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        always_comb begin
            active[n] = pol_high[n] ? sync2_q[n] : ~sync2_q[n];
            if (edge_mode[n]) begin
                hw_set[n] = active[n] & ~active_d_q[n];
            end else begin
                hw_set[n] = active[n];
            end
        end
    end

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & edge_mode) & $past(hw_set & edge_mode)) == '0);

endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_set,
    input  logic [NSRC-1:0] sw_set,
    input  logic [NSRC-1:0] sw_clr,
    output logic [NSRC-1:0] status_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~sw_clr) | sw_set | hw_set;
        end
    end

    // R5
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(sw_clr & ~sw_set & ~hw_set) |=>
        ((status_q & $past(sw_clr & ~sw_set & ~hw_set)) == '0));

    // R6
    force_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |sw_set |=> ((status_q & $past(sw_set)) == $past(sw_set)));

endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
    parameter int NSRC       = 32,
    parameter int SLOT_SHIFT = 9
) (
    input  logic [NSRC-1:0] masked,
    input  logic            low_first,
    input  logic [31:0]     base,
    output logic [31:0]     vector
);

    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NSRC - 1);

    logic             any;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] slot;

    always_comb begin
        any = |masked;
        win = '0;
        if (low_first) begin
            for (int n = NSRC - 1; n >= 0; n--) begin
                if (masked[n]) win = IDX_W'(n);
            end
        end else begin
            for (int n = 0; n < NSRC; n++) begin
                if (masked[n]) win = IDX_W'(n);
            end
        end
        slot   = low_first ? win : (TOP_IDX - win);
        vector = any ? (base + (32'(slot) << SLOT_SHIFT)) : 32'h0;
        // R9
        if (any) begin
            win_pending_chk: assert (masked[win]);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int NSRC       = 32,
    parameter int ADDR_W     = 6,
    parameter int SLOT_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              irq_crit,
    output logic              irq_norm
);

    localparam int WIX_W = ADDR_W - 2;

    logic [NSRC-1:0]  en_q;
    logic [NSRC-1:0]  crit_q;
    logic [NSRC-1:0]  pol_q;
    logic [NSRC-1:0]  trig_q;
    logic [31:0]      cfg_q;
    logic [NSRC-1:0]  status;
    logic [NSRC-1:0]  masked;
    logic [NSRC-1:0]  hw_set;
    logic [NSRC-1:0]  sw_set;
    logic [NSRC-1:0]  sw_clr;
    logic [NSRC-1:0]  wsrc;
    logic [31:0]      wrev;
    logic [31:0]      vector;
    logic [WIX_W-1:0] wix;
    logic             aligned;

    assign wix     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wrev    = rev_bits(bus_wdata);
    assign wsrc    = wrev[NSRC-1:0];

    function automatic logic hit(input logic [WIX_W-1:0] w, input logic [3:0] target);
        return aligned && (w == WIX_W'(target));
    endfunction

    assign sw_clr = (bus_we && hit(wix, WIX_STATUS)) ? wsrc : '0;
    assign sw_set = (bus_we && hit(wix, WIX_FORCE))  ? wsrc : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '1;
            trig_q <= '0;
            cfg_q  <= '0;
        end else if (bus_we) begin
            if (hit(wix, WIX_ENABLE)) en_q   <= wsrc;
            if (hit(wix, WIX_CRIT))   crit_q <= wsrc;
            if (hit(wix, WIX_POL))    pol_q  <= wsrc;
            if (hit(wix, WIX_TRIG))   trig_q <= wsrc;
            if (hit(wix, WIX_CONFIG)) cfg_q  <= bus_wdata;
        end
    end

    irq_condition #(.NSRC(NSRC)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_raw  (irq_src),
        .pol_high (pol_q),
        .edge_mode(trig_q),
        .hw_set   (hw_set)
    );

    irq_status #(.NSRC(NSRC)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .status_q(status)
    );

    assign masked = status & en_q;

    irq_prio_vec #(.NSRC(NSRC), .SLOT_SHIFT(SLOT_SHIFT)) u_prio (
        .masked   (masked),
        .low_first(cfg_q[0]),
        .base     ({cfg_q[31:2], 2'b00}),
        .vector   (vector)
    );

    assign irq_crit = |(masked & crit_q);
    assign irq_norm = |(masked & ~crit_q);

    always_comb begin
        bus_rdata = 32'h0;
        if (aligned) begin
            case (wix)
                WIX_W'(WIX_STATUS): bus_rdata = rev_bits(32'(status));
                WIX_W'(WIX_ENABLE): bus_rdata = rev_bits(32'(en_q));
                WIX_W'(WIX_CRIT):   bus_rdata = rev_bits(32'(crit_q));
                WIX_W'(WIX_POL):    bus_rdata = rev_bits(32'(pol_q));
                WIX_W'(WIX_TRIG):   bus_rdata = rev_bits(32'(trig_q));
                WIX_W'(WIX_MASKED): bus_rdata = rev_bits(32'(masked));
                WIX_W'(WIX_VECTOR): bus_rdata = vector;
                WIX_W'(WIX_CONFIG): bus_rdata = cfg_q;
                default:            bus_rdata = 32'h0;
            endcase
        end
    end

    // R8
    crit_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> ((status & en_q & crit_q) != '0));

    // R8
    norm_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> ((status & en_q & ~crit_q) != '0));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic        irq_crit;
    logic        irq_norm;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_st, m_en, m_crit, m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .irq_crit(irq_crit), .irq_norm(irq_norm)
    );

    function automatic logic [31:0] bit_of(input int n);
        return 32'h8000_0000 >> n;
    endfunction

    function automatic logic [31:0] exp_vec(input logic [31:0] m, input logic [31:0] cfg);
        logic [31:0] base = cfg & ~32'h3;
        if (m == 0) return 32'h0;
        if (cfg[0]) begin
            for (int n = 0; n < 32; n++) if (m[31-n]) return base + 32'(n) * 512;
        end else begin
            for (int n = 31; n >= 0; n--) if (m[31-n]) return base + 32'(31 - n) * 512;
        end
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, d); chk("R1 status reset", d, 32'h0);
        rd(6'h08, d); chk("R1 enable reset", d, 32'h0);
        rd(6'h10, d); chk("R1 polarity reset", d, 32'hFFFF_FFFF);
        rd(6'h1C, d); chk("R1 vector reset", d, 32'h0);
        chk("R1 lines reset", {30'd0, irq_crit, irq_norm}, 32'h0);

        // R2 level source 5, active high
        irq_src[5] = 1'b1; settle();
        rd(6'h00, d); chk("R2 level set", d, bit_of(5));
        // R5 clear while still active -> pending again
        wr(6'h00, bit_of(5)); settle();
        rd(6'h00, d); chk("R5 level reasserts", d, bit_of(5));
        // R8 routing of source 5 as critical
        wr(6'h08, bit_of(5)); wr(6'h0C, bit_of(5));
        chk("R8 crit line", {30'd0, irq_crit, irq_norm}, 32'h2);
        wr(6'h0C, 32'h0);
        chk("R8 norm line", {30'd0, irq_crit, irq_norm}, 32'h1);
        wr(6'h08, 32'h0);
        irq_src[5] = 1'b0; settle();
        wr(6'h00, bit_of(5));
        rd(6'h00, d); chk("R5 clear inactive", d, 32'h0);

        // R3 active-low source 7
        wr(6'h10, ~bit_of(7)); settle();
        rd(6'h00, d); chk("R3 active low", d, bit_of(7));
        wr(6'h10, 32'hFFFF_FFFF); settle();
        wr(6'h00, bit_of(7));
        rd(6'h00, d); chk("R3 active high idle", d, 32'h0);

        // R4 edge source 9
        wr(6'h14, bit_of(9));
        irq_src[9] = 1'b1; settle();
        rd(6'h00, d); chk("R4 edge set", d, bit_of(9));
        wr(6'h00, bit_of(9)); settle();
        rd(6'h00, d); chk("R4 held input stays clear", d, 32'h0);
        irq_src[9] = 1'b0; settle();
        irq_src[9] = 1'b1; settle();
        rd(6'h00, d); chk("R4 second edge", d, bit_of(9));
        wr(6'h00, bit_of(9));
        irq_src[9] = 1'b0; settle();
        wr(6'h14, 32'h0);

        // R6 force, reads zero
        wr(6'h04, bit_of(3) | bit_of(20));
        rd(6'h00, d); chk("R6 force", d, bit_of(3) | bit_of(20));
        rd(6'h04, d); chk("R6 force reads zero", d, 32'h0);
        wr(6'h08, 32'hFFFF_FFFF);
        // R9 / R10 vector directions
        wr(6'h20, 32'h1000_0003);
        rd(6'h1C, d); chk("R9 low first", d, 32'h1000_0000 + 3 * 512);
        wr(6'h20, 32'h2000_0002);
        rd(6'h1C, d); chk("R10 high first", d, 32'h2000_0000 + 11 * 512);
        rd(6'h20, d); chk("R11 config readback", d, 32'h2000_0002);
        // R12 read-only words ignore writes, unmapped reads zero
        wr(6'h18, 32'h0);
        rd(6'h18, d); chk("R12 masked write ignored", d, bit_of(3) | bit_of(20));
        wr(6'h1C, 32'h0);
        rd(6'h1C, d); chk("R12 vector write ignored", d, 32'h2000_0000 + 11 * 512);
        rd(6'h28, d); chk("R12 unmapped", d, 32'h0);
        rd(6'h09, d); chk("R12 unaligned", d, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h1C, d); chk("R11 vector idle", d, 32'h0);

        // Random phase: inputs idle, software set/clear and configuration
        m_st = 0; m_en = 32'hFFFF_FFFF; m_crit = 0; m_cfg = 32'h2000_0002;
        for (int it = 0; it < 300; it++) begin
            logic [31:0] v = $urandom & $urandom;
            case ($urandom % 5)
                0: begin wr(6'h00, v); m_st &= ~v; end
                1: begin wr(6'h04, v); m_st |= v; end
                2: begin wr(6'h08, v | $urandom); m_en = bus_wdata; end
                3: begin wr(6'h0C, v); m_crit = v; end
                default: begin v = $urandom; wr(6'h20, v); m_cfg = v; end
            endcase
            rd(6'h00, d); chk("R5/R6 status model", d, m_st);
            rd(6'h18, d); chk("R7 masked", d, m_st & m_en);
            rd(6'h1C, d); chk(m_cfg[0] ? "R9 vector" : "R10 vector", d, exp_vec(m_st & m_en, m_cfg));
            chk("R8 lines", {30'd0, irq_crit, irq_norm},
                {30'd0, |(m_st & m_en & m_crit), |(m_st & m_en & ~m_crit)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule